// File: doc/BRIEF.md
# Stipple Masked-Fill Write Decoder

This block turns one 64-bit stipple command written on the host bus into a burst of single-pixel writes to a framebuffer memory port. The write address selects a run of 32 horizontally adjacent pixels in a framebuffer that is 1152 pixels wide. The write data carries one colour value and a 32-bit enable mask. Every pixel whose mask bit is set receives the colour. Every other pixel in the run is left alone. A single bus write can therefore fill up to 32 pixels, which makes it useful for solid fills, text and patterned spans.

The block keeps no state from one command to the next. Each command brings its own location, colour and mask. While a run is being issued, `busy` is high and any further bus write is dropped. The requester must wait for `busy` to fall before it presents the next command.

There are two modes, chosen per command by `raw_mode`. In normal mode the block writes only the 24 colour bits and leaves the two top pixel bits as they were. In raw mode it also writes the two top bits from the command. Commands whose address or opcode is malformed are refused, and a sticky error flag records the refusal.

Top module: `stipple_fill_decoder`

## Requirements
- R1: After reset, `busy`, `pix_we`, `pix_top_we` and `err_flag` are all 0.
- R2: The run base is the byte address bits [22:3]. A set mask bit k (data bit k, 0..31) writes pixel address base + (31 − k): mask bit 31 is the leftmost pixel and bit 0 is the rightmost.
- R3: Only pixels whose mask bit is 1 are written, exactly one per cycle, in ascending pixel address. The first write appears in the cycle after the command is accepted.
- R4: The 24 low bits of every written pixel are {data[55:48] blue, data[47:40] green, data[39:32] red}, with red in pixel bits [7:0].
- R5: In raw mode, `pix_top_we` is 1 and pixel bits [25:24] equal data[57:56]. In normal mode, `pix_top_we` is 0 and pixel bits [25:24] are 0.
- R6: `busy` is 1 in exactly the cycles in which a pixel write is issued, so it stays high for as many cycles as the mask has set bits.
- R7: A bus write presented while `busy` is 1 is ignored. It does not alter the run in progress and starts no writes afterwards.
- R8: A valid command with a zero mask completes at once. It performs no memory write, does not raise `busy` and sets no error.
- R9: A command whose byte address bits [2:0] are not zero is refused. It causes no writes and sets `err_flag`.
- R10: A command whose pixel column is not a multiple of 32 is refused. It causes no writes and sets `err_flag`.
- R11: A command is refused and sets `err_flag` if data[63:60] is not 0011, or if its reserved bits are nonzero. The reserved bits are data[59:56] in normal mode and data[59:58] in raw mode.
- R12: `err_flag` stays at 1 until reset, and valid commands are still carried out while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus write strobe for one command |
| wr_addr | input | 23 | Byte address of the command |
| wr_data | input | 64 | Command data: opcode, top bits, colour, mask |
| raw_mode | input | 1 | 1 writes all 26 pixel bits, 0 preserves the top two |
| busy | output | 1 | Run in progress; bus writes are dropped |
| err_flag | output | 1 | Sticky flag for a refused command |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 20 | Linear pixel address of the write |
| pix_data | output | 26 | Pixel value to write |
| pix_top_we | output | 1 | Enable for pixel bits [25:24] |

## Verification
The bench sends commands with random run locations, random colours and random masks, in both modes. It also sends directed masks:
- A full mask separates correct ordering from reversed ordering.
- A single-bit mask at each end of the run exposes an off-by-one in the offset.
- An alternating mask proves that cleared bits are skipped rather than written.
- A zero mask tells immediate completion apart from a spurious write.

Malformed commands cover each refusal cause on its own: a misaligned byte address, an unaligned column, a wrong opcode and nonzero reserved bits. Bus writes injected during a run separate a correct hold-off from a design that restarts or merges commands.

// File: rtl/stip_pkg.sv
// Shared constants and types for the stipple fill decoder.
// Assumes the fixed 64-bit command layout: opcode, reserved/top bits,
// 24-bit colour, 32-bit mask.
package stip_pkg;
    localparam int PIX_W    = 26;
    localparam int COLOR_W  = 24;
    localparam int TOP_W    = 2;
    localparam int DATA_W   = 64;
    localparam int RUN_LEN  = 32;
    localparam int OFS_W    = $clog2(RUN_LEN);
    localparam logic [3:0] OP_COPY = 4'b0011;

    // Pixel payload carried through a run.
    typedef struct packed {
        logic [PIX_W-1:0] value;
        logic             top_we;
    } stip_pix_t;
endpackage

// File: rtl/stip_cmd_decode.sv
// Splits a stipple command into run base, mask and pixel payload and
// checks it. The check covers byte alignment, 32-pixel column alignment,
// the opcode and the reserved bits.
// Assumes the row width is given in pixels. The column test picks a cheap
// low-bit compare when the row width is a multiple of the run length.
module stip_cmd_decode
    import stip_pkg::*;
#(
    parameter int LOC_W      = 20,
    parameter int ROW_PIXELS = 1152
) (
    input  logic [LOC_W+2:0]   addr,
    input  logic [DATA_W-1:0]  data,
    input  logic               raw,
    output logic [LOC_W-1:0]   loc,
    output logic [RUN_LEN-1:0] mask,
    output stip_pix_t          pix,
    output logic               ok
);
    logic addr_ok;
    logic run_ok;
    logic op_ok;
    logic rsv_ok;

    assign loc     = addr[LOC_W+2:3];
    assign mask    = data[RUN_LEN-1:0];
    assign addr_ok = (addr[2:0] == 3'b000);

    // Column alignment: pick the structure that suits the row width.
    generate
        if (ROW_PIXELS % RUN_LEN == 0) begin : g_low_bits
            assign run_ok = (loc[OFS_W-1:0] == '0);
        end else begin : g_divide
            logic [LOC_W-1:0] col;
            assign col    = loc % LOC_W'(ROW_PIXELS);
            assign run_ok = ((col % LOC_W'(RUN_LEN)) == '0);
        end
    endgenerate

    // Opcode and reserved-bit screening; raw mode frees bits [57:56].
    always_comb begin
        op_ok  = (data[63:60] == OP_COPY);
        rsv_ok = raw ? (data[59:58] == 2'b00) : (data[59:56] == 4'b0000);
    end

    // Pixel payload: colour always, top bits only in raw mode.
    always_comb begin
        pix.value  = {(raw ? data[57:56] : 2'b00), data[55:32]};
        pix.top_we = raw;
    end

    assign ok = addr_ok && run_ok && op_ok && rsv_ok;
endmodule

// File: rtl/stip_lead_pick.sv
// Finds the most significant set bit of a pending mask. That bit is the
// leftmost remaining pixel. Returns its offset from the run start and a
// one-hot vector to clear it.
// Assumes bit RUN_LEN-1 is offset 0.
module stip_lead_pick
    import stip_pkg::*;
(
    input  logic [RUN_LEN-1:0] vec,
    output logic [OFS_W-1:0]   offset,
    output logic [RUN_LEN-1:0] clr
);
    logic [OFS_W-1:0] idx;

    // Scan upward so the highest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < RUN_LEN; i++) begin
            if (vec[i]) idx = OFS_W'(i);
        end
    end

    // Offset from the left edge of the run, and clear vector.
    always_comb begin
        offset = OFS_W'(RUN_LEN - 1) - idx;
        clr    = '0;
        clr[idx] = |vec;
    end
endmodule

// File: rtl/stip_run_engine.sv
// Holds one accepted run and issues one pixel write per cycle until the
// mask is exhausted. Busy is simply "mask not empty".
// Assumes load is only asserted while idle.
module stip_run_engine
    import stip_pkg::*;
#(
    parameter int LOC_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LOC_W-1:0]   loc,
    input  logic [RUN_LEN-1:0] mask,
    input  stip_pix_t          pix_in,
    output logic               busy,
    output logic               pix_we,
    output logic [LOC_W-1:0]   pix_addr,
    output logic [PIX_W-1:0]   pix_data,
    output logic               pix_top_we
);
    logic [RUN_LEN-1:0] mask_q;
    logic [LOC_W-1:0]   base_q;
    stip_pix_t          pix_q;
    logic [OFS_W-1:0]   offset;
    logic [RUN_LEN-1:0] clr;

    stip_lead_pick u_pick (
        .vec    (mask_q),
        .offset (offset),
        .clr    (clr)
    );

    // Run state: load a command, then retire one mask bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= '0;
            pix_q  <= '0;
        end else if (load) begin
            mask_q <= mask;
            base_q <= loc;
            pix_q  <= pix_in;
        end else if (busy) begin
            mask_q <= mask_q & ~clr;
        end
    end

    // Memory port drive from the held run.
    always_comb begin
        busy       = |mask_q;
        pix_we     = busy;
        pix_addr   = base_q + LOC_W'(offset);
        pix_data   = busy ? pix_q.value : '0;
        pix_top_we = busy && pix_q.top_we;
    end

    // R3: each busy cycle retires exactly one pixel.
    a_r3_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(mask_q) + 1 == $countones($past(mask_q))));

    // R7: the run base does not move while pixels remain.
    a_r7_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mask_q) > 1) |=> $stable(base_q));

    // R5: normal-mode writes never carry top bits.
    a_r5_top_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && !pix_top_we) |-> (pix_data[PIX_W-1:COLOR_W] == '0));
endmodule

// File: rtl/stipple_fill_decoder.sv
// Top of the stipple fill decoder. It accepts one bus command when idle,
// screens it, keeps a sticky error flag for refused commands, and hands
// valid non-empty runs to the run engine.
// Assumes the requester waits for busy low. Writes presented while busy
// are dropped.
module stipple_fill_decoder
    import stip_pkg::*;
#(
    parameter int LOC_W      = 20,
    parameter int ROW_PIXELS = 1152,
    localparam int ADDR_W    = LOC_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              raw_mode,
    output logic              busy,
    output logic              err_flag,
    output logic              pix_we,
    output logic [LOC_W-1:0]  pix_addr,
    output logic [PIX_W-1:0]  pix_data,
    output logic              pix_top_we
);
    logic [LOC_W-1:0]   cmd_loc;
    logic [RUN_LEN-1:0] cmd_mask;
    stip_pix_t          cmd_pix;
    logic               cmd_ok;
    logic               accept;
    logic               load;
    logic               err_q;

    stip_cmd_decode #(
        .LOC_W      (LOC_W),
        .ROW_PIXELS (ROW_PIXELS)
    ) u_decode (
        .addr (wr_addr),
        .data (wr_data),
        .raw  (raw_mode),
        .loc  (cmd_loc),
        .mask (cmd_mask),
        .pix  (cmd_pix),
        .ok   (cmd_ok)
    );

    stip_run_engine #(
        .LOC_W (LOC_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .loc        (cmd_loc),
        .mask       (cmd_mask),
        .pix_in     (cmd_pix),
        .busy       (busy),
        .pix_we     (pix_we),
        .pix_addr   (pix_addr),
        .pix_data   (pix_data),
        .pix_top_we (pix_top_we)
    );

    // Command acceptance: only when idle; empty masks load nothing.
    always_comb begin
        accept = wr_valid && !busy;
        load   = accept && cmd_ok && (|cmd_mask);
    end

    // Sticky error flag for refused commands.
    always_ff @(posedge clk) begin
        if (!rst_n)              err_q <= 1'b0;
        else if (accept && !cmd_ok) err_q <= 1'b1;
    end

    assign err_flag = err_q;

    // R12: once set, the error flag stays set.
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9 R10 R11: a refused command starts no run.
    a_r9_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_ok) |=> !busy);

    // R8: an empty mask starts no run and sets no error.
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_ok && cmd_mask == '0) |=> (!busy && $stable(err_q)));

    // R6: a loaded run is busy on the next cycle.
    a_r6_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: tb/stipple_fill_decoder_bench.sv
`timescale 1ns/1ps
module stipple_fill_decoder_bench;
    localparam int LOC_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [22:0]       wr_addr = '0;
    logic [63:0]       wr_data = '0;
    logic              raw_mode = 1'b0;
    logic              busy;
    logic              err_flag;
    logic              pix_we;
    logic [LOC_W-1:0]  pix_addr;
    logic [25:0]       pix_data;
    logic              pix_top_we;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit err_exp = 1'b0;

    always #10 clk = ~clk;

    stipple_fill_decoder u_stipple_fill_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .raw_mode(raw_mode), .busy(busy), .err_flag(err_flag),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .pix_top_we(pix_top_we)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_data(input logic [3:0] op, input logic [3:0] hi,
                                            input logic [23:0] bgr, input logic [31:0] m);
        return {op, hi, bgr, m};
    endfunction

    function automatic bit cmd_good(input logic [22:0] a, input logic [63:0] d, input bit raw);
        bit rsv;
        rsv = raw ? (d[59:58] == 2'b00) : (d[59:56] == 4'b0000);
        return (a[2:0] == 3'b000) && ((a[22:3] % 1152) % 32 == 0) &&
               (d[63:60] == 4'b0011) && rsv;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        err_exp = 1'b0;
        chk("R1", "busy after reset", 64'(busy), 64'd0);
        chk("R1", "pix_we after reset", 64'(pix_we), 64'd0);
        chk("R1", "pix_top_we after reset", 64'(pix_top_we), 64'd0);
        chk("R1", "err_flag after reset", 64'(err_flag), 64'd0);
    endtask

    // Apply one command and check the whole resulting pixel stream.
    task automatic run_cmd(input logic [22:0] a, input logic [63:0] d,
                           input bit raw, input bit poke);
        bit good;
        logic [19:0] base;
        logic [25:0] exp_pix;
        good = cmd_good(a, d, raw);
        base = a[22:3];
        exp_pix = {(raw ? d[57:56] : 2'b00), d[55:32]};
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr = a;
        wr_data = d;
        raw_mode = raw;
        @(negedge clk);
        if (poke && good && d[31:0] != 0) begin
            wr_addr = a + 23'h100;
            wr_data = mk_data(4'b0011, 4'b0000, 24'hA5A5A5, 32'hFFFF_FFFF);
            raw_mode = ~raw;
        end else begin
            wr_valid = 1'b0;
        end
        if (!good) begin
            err_exp = 1'b1;
            chk("R9 R10 R11", "busy on refused command", 64'(busy), 64'd0);
            chk("R9 R10 R11", "pix_we on refused command", 64'(pix_we), 64'd0);
            chk("R9 R10 R11", "err_flag on refused command", 64'(err_flag), 64'd1);
            return;
        end
        if (d[31:0] == 0) begin
            chk("R8", "busy on empty mask", 64'(busy), 64'd0);
            chk("R8", "pix_we on empty mask", 64'(pix_we), 64'd0);
            chk("R8", "err_flag on empty mask", 64'(err_flag), 64'(err_exp));
            return;
        end
        for (int b = 31; b >= 0; b--) begin
            if (d[b]) begin
                chk("R3 R6", "pix_we/busy in run", {62'd0, busy, pix_we}, 64'd3);
                chk("R2", "pixel address", 64'(pix_addr), 64'(base + 20'(31 - b)));
                chk("R4", "colour bits", 64'(pix_data[23:0]), 64'(exp_pix[23:0]));
                chk("R5", "top bits", 64'(pix_data[25:24]), 64'(exp_pix[25:24]));
                chk("R5", "top enable", 64'(pix_top_we), 64'(raw));
                @(negedge clk);
            end
        end
        wr_valid = 1'b0;
        chk("R6", "busy after run", 64'(busy), 64'd0);
        chk("R3", "pix_we after run", 64'(pix_we), 64'd0);
        chk("R12", "err_flag during good run", 64'(err_flag), 64'(err_exp));
        if (poke) begin
            @(negedge clk);
            chk("R7", "no writes from dropped command", 64'(pix_we), 64'd0);
        end
    endtask

    function automatic logic [22:0] run_addr(input int row, input int grp);
        logic [19:0] loc;
        loc = 20'(row * 1152 + grp * 32);
        return {loc, 3'b000};
    endfunction

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        do_reset();
        // Directed patterns.
        run_cmd(run_addr(0, 0),    mk_data(4'b0011, 4'b0000, 24'h112233, 32'hFFFF_FFFF), 1'b0, 1'b0); // R3 full
        run_cmd(run_addr(5, 35),   mk_data(4'b0011, 4'b0000, 24'hABCDEF, 32'h8000_0000), 1'b0, 1'b0); // R2 left end
        run_cmd(run_addr(7, 3),    mk_data(4'b0011, 4'b0000, 24'h00FF00, 32'h0000_0001), 1'b0, 1'b0); // R2 right end
        run_cmd(run_addr(9, 10),   mk_data(4'b0011, 4'b0010, 24'h123456, 32'hAAAA_5555), 1'b1, 1'b0); // R5 raw
        run_cmd(run_addr(9, 11),   mk_data(4'b0011, 4'b0001, 24'h654321, 32'h0F0F_00F0), 1'b1, 1'b0); // R5 raw
        run_cmd(run_addr(2, 2),    mk_data(4'b0011, 4'b0000, 24'hFFFFFF, 32'h0000_0000), 1'b0, 1'b0); // R8
        run_cmd(run_addr(3, 4),    mk_data(4'b0011, 4'b0000, 24'h0A0B0C, 32'h1234_5678), 1'b0, 1'b1); // R7 poke
        run_cmd(run_addr(4, 5),    mk_data(4'b0011, 4'b0011, 24'h0C0B0A, 32'hF000_000F), 1'b1, 1'b1); // R7 poke raw
        // Refusals, each with a fresh reset so the flag is observed per cause.
        run_cmd(run_addr(1, 1) | 23'h4, mk_data(4'b0011, 4'b0000, 24'h1, 32'hFF), 1'b0, 1'b0);     // R9
        do_reset();
        run_cmd({20'(1152 + 33), 3'b000}, mk_data(4'b0011, 4'b0000, 24'h1, 32'hFF), 1'b0, 1'b0);   // R10
        do_reset();
        run_cmd(run_addr(1, 1), mk_data(4'b0111, 4'b0000, 24'h1, 32'hFF), 1'b0, 1'b0);              // R11 opcode
        do_reset();
        run_cmd(run_addr(1, 1), mk_data(4'b0011, 4'b0001, 24'h1, 32'hFF), 1'b0, 1'b0);              // R11 reserved normal
        do_reset();
        run_cmd(run_addr(1, 1), mk_data(4'b0011, 4'b0100, 24'h1, 32'hFF), 1'b1, 1'b0);              // R11 reserved raw
        // R12: error set, then a valid command still runs and the flag holds.
        run_cmd(run_addr(6, 6), mk_data(4'b0011, 4'b0000, 24'h777777, 32'h0101_0101), 1'b0, 1'b0);
        @(negedge clk);
        chk("R12", "err_flag held", 64'(err_flag), 64'd1);
        do_reset();
        // Random commands.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] m;
            bit raw;
            logic [3:0] hi;
            raw = $urandom % 2;
            hi = raw ? 4'($urandom % 4) : 4'b0000;
            case ($urandom % 4)
                0: m = $urandom & $urandom;
                1: m = $urandom | $urandom;
                2: m = 32'd1 << ($urandom % 32);
                default: m = $urandom;
            endcase
            run_cmd(run_addr(int'($urandom % 900), int'($urandom % 36)),
                    mk_data(4'b0011, hi, 24'($urandom), m), raw, ($urandom % 8) == 0);
        end
        summary();
    end
endmodule